// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller with Timed Refresh

This block is a synchronous controller placed between a simple host request port and an asynchronous dynamic memory whose row and column addresses share one set of pins. The host presents a flat address, a write flag and write data under a valid/ready handshake. The controller splits the address into a row half (upper bits) and a column half (lower bits). It drives the active-low row strobe, column strobe and write strobe, and every interval it observes is a parameter counted in clock cycles. Read data comes back on a separate port together with a single-cycle valid pulse.

The controller keeps a row open after an access. A following request to the same row is served by cycling only the column strobe. A request to another row closes the open row, waits out the precharge time and opens the new row. A free-running timer requests one refresh every `CLK_MHZ*REFRESH_NS/1000` cycles. The controller serves that refresh at the next access boundary by driving the column strobe low before the row strobe, so the memory takes the refresh row from its own counter.

The states are:
- `ST_IDLE`: no row open.
- `ST_ROW_SET`: row address on the pins.
- `ST_RAS_WAIT`: row strobe low for `T_RCD` cycles.
- `ST_COL_SET`: column address on the pins.
- `ST_COL_ACC`: column strobe low.
- `ST_PAGE`: row held open.
- `ST_PRECHARGE`: row strobe high for `T_RP` cycles.
- `ST_REF_CAS`: column strobe low first.
- `ST_REF_RAS`: both strobes low for `T_REF_RAS` cycles.

The transitions are:
- IDLE to REF_CAS when a refresh is due.
- IDLE to ROW_SET when a request is accepted.
- ROW_SET to RAS_WAIT.
- RAS_WAIT to COL_SET.
- COL_SET to COL_ACC.
- COL_ACC to PAGE.
- PAGE to COL_SET when a same-row request is accepted.
- PAGE to PRECHARGE when a refresh is due or a request targets another row.
- PRECHARGE to IDLE.
- REF_CAS to REF_RAS.
- REF_RAS to PRECHARGE.

Top module: `dram_mux_ctrl`

## Requirements
- R1: In reset and in idle, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are all high. Right after reset, with no refresh due, `req_ready` is high.
- R2: The row address is the upper `ROW_W` bits of `req_addr`. It is on `dram_addr` for at least one cycle before `dram_ras_n` falls and does not change in the cycle it falls.
- R3: The column address is the lower `COL_W` bits of `req_addr`. It is placed on `dram_addr` while `dram_cas_n` is high, and then `dram_cas_n` falls. `dram_we_n` is low only while `dram_cas_n` is low in a host write, and `dram_din` then carries the write data.
- R4: A host access ends with `dram_cas_n` rising while `dram_ras_n` stays low. `dram_ras_n` rises only in a cycle that follows a cycle with `dram_cas_n` high.
- R5: Every falling edge of `dram_ras_n` comes after at least `T_RP` cycles with it high.
- R6: Read data is sampled only once `dram_ras_n` has been low for `T_RAC` cycles and `dram_cas_n` low for `T_CAC` cycles. It is returned on `rsp_rdata` with `rsp_valid` high for exactly one cycle.
- R7: Consecutive requests to the open row cause no new falling edge of `dram_ras_n`.
- R8: A request to a different row closes the open row, precharges and opens the new row, so each row change costs one new falling edge of `dram_ras_n`.
- R9: A refresh is started every `CLK_MHZ*REFRESH_NS/1000` cycles. With no host traffic, consecutive refreshes are exactly that many cycles apart.
- R10: In a refresh, `dram_cas_n` falls exactly one cycle before `dram_ras_n`, and `dram_we_n` stays high.
- R11: A due refresh wins over a waiting host request, but only at an access boundary. An open row is closed and precharged first, and a host request that is held continuously still completes with correct data.
- R12: `req_ready` is low while a refresh or a precharge is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Flat address, row in upper bits |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_din | output | DATA_W | Data written to memory |
| dram_dout | input | DATA_W | Data read from memory |

## Verification
The refresh timer and a host request can both be due in the same cycle. This is provoked by issuing back-to-back reads to one row for several refresh periods, so that expiries land while a request is waiting in the open-row state. The bench judges the outcome from the pins. Every read must return the value written earlier. The gap between refreshes must stay within one access length of the period. Each refresh must cost exactly one extra row opening. The memory model also flags any refresh that begins without a full precharge or while `req_ready` is high.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW_SET,
        ST_RAS_WAIT,
        ST_COL_SET,
        ST_COL_ACC,
        ST_PAGE,
        ST_PRECHARGE,
        ST_REF_CAS,
        ST_REF_RAS
    } ctrl_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
    parameter int ROW_W = 10,
    parameter int COL_W = 10,
    parameter int MUX_W = 10
) (
    input  logic [ROW_W+COL_W-1:0] flat_addr,
    output logic [ROW_W-1:0]       row_part,
    output logic [COL_W-1:0]       col_part
);
    assign row_part = flat_addr[ROW_W+COL_W-1:COL_W];
    assign col_part = flat_addr[COL_W-1:0];
endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int PERIOD = 1953
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic due
);
    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] tick_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
            due    <= 1'b0;
        end else begin
            if (tick_q == LAST) begin
                tick_q <= '0;
                due    <= 1'b1;
            end else begin
                tick_q <= tick_q + 1'b1;
                if (ack) due <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W      = 10,
    parameter int COL_W      = 10,
    parameter int DATA_W     = 16,
    parameter int CLK_MHZ    = 125,
    parameter int REFRESH_NS = 15625,
    parameter int T_RCD      = 2,
    parameter int T_RAC      = 7,
    parameter int T_CAC      = 3,
    parameter int T_RP       = 4,
    parameter int T_REF_RAS  = 7,
    localparam int ADDR_W    = ROW_W + COL_W,
    localparam int MUX_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [MUX_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [DATA_W-1:0] dram_din,
    input  logic [DATA_W-1:0] dram_dout
);
    localparam int REF_CYC = CLK_MHZ * REFRESH_NS / 1000;
    localparam int MAX_T   = max2(max2(T_RCD, T_CAC), max2(T_RP, T_REF_RAS));
    localparam int CNT_W   = $clog2(MAX_T + 2);
    localparam int RAC_W   = $clog2(T_RAC + 2);
    localparam logic [CNT_W-1:0] C_RCD = CNT_W'(T_RCD);
    localparam logic [CNT_W-1:0] C_CAC = CNT_W'(T_CAC);
    localparam logic [CNT_W-1:0] C_RP  = CNT_W'(T_RP);
    localparam logic [CNT_W-1:0] C_REF = CNT_W'(T_REF_RAS);
    localparam logic [RAC_W-1:0] C_RAC = RAC_W'(T_RAC);

    ctrl_state_t       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [RAC_W-1:0]  ras_cnt_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;
    logic [ROW_W-1:0]  in_row;
    logic [COL_W-1:0]  in_col;
    logic              ref_due, ref_ack;
    logic              take_req, take_row, data_ready;
    logic [MUX_W-1:0]  row_pad, col_pad;

    dram_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .MUX_W(MUX_W)) u_split (
        .flat_addr (req_addr),
        .row_part  (in_row),
        .col_part  (in_col)
    );

    dram_refresh_timer #(.PERIOD(REF_CYC)) u_ref_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .ack   (ref_ack),
        .due   (ref_due)
    );

    generate
        if (ROW_W < MUX_W) begin : g_row_pad
            assign row_pad = {{(MUX_W-ROW_W){1'b0}}, row_q};
        end else begin : g_row_full
            assign row_pad = row_q;
        end
        if (COL_W < MUX_W) begin : g_col_pad
            assign col_pad = {{(MUX_W-COL_W){1'b0}}, col_q};
        end else begin : g_col_full
            assign col_pad = col_q;
        end
    endgenerate

    // ready: idle with no refresh pending, or open row hit
    always_comb begin
        req_ready = 1'b0;
        if (state_q == ST_IDLE && !ref_due) req_ready = 1'b1;
        if (state_q == ST_PAGE && !ref_due && in_row == row_q) req_ready = 1'b1;
    end

    assign data_ready = (cnt_q >= C_CAC) && (ras_cnt_q >= C_RAC);

    // next-state logic
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q + 1'b1;
        ref_ack  = 1'b0;
        take_req = 1'b0;
        take_row = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_due) begin
                    state_d = ST_REF_CAS;
                    ref_ack = 1'b1;
                end else if (req_valid) begin
                    state_d  = ST_ROW_SET;
                    take_req = 1'b1;
                    take_row = 1'b1;
                end
            end
            ST_ROW_SET: begin
                state_d = ST_RAS_WAIT;
                cnt_d   = CNT_W'(1);
            end
            ST_RAS_WAIT: if (cnt_q >= C_RCD) state_d = ST_COL_SET;
            ST_COL_SET: begin
                state_d = ST_COL_ACC;
                cnt_d   = CNT_W'(1);
            end
            ST_COL_ACC: if (data_ready) state_d = ST_PAGE;
            ST_PAGE: begin
                if (ref_due || (req_valid && in_row != row_q)) begin
                    state_d = ST_PRECHARGE;
                    cnt_d   = CNT_W'(1);
                end else if (req_valid) begin
                    state_d  = ST_COL_SET;
                    take_req = 1'b1;
                end
            end
            ST_PRECHARGE: if (cnt_q >= C_RP) state_d = ST_IDLE;
            ST_REF_CAS: begin
                state_d = ST_REF_RAS;
                cnt_d   = CNT_W'(1);
            end
            ST_REF_RAS: begin
                if (cnt_q >= C_REF) begin
                    state_d = ST_PRECHARGE;
                    cnt_d   = CNT_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            ras_cnt_q <= '0;
            row_q     <= '0;
            col_q     <= '0;
            wr_q      <= 1'b0;
            wdata_q   <= '0;
            rdata_q   <= '0;
            rvalid_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            rvalid_q <= 1'b0;
            if (state_q == ST_ROW_SET) ras_cnt_q <= RAC_W'(1);
            else if (ras_cnt_q < C_RAC) ras_cnt_q <= ras_cnt_q + 1'b1;
            if (take_row) row_q <= in_row;
            if (take_req) begin
                col_q   <= in_col;
                wr_q    <= req_write;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_COL_ACC && data_ready && !wr_q) begin
                rdata_q  <= dram_dout;
                rvalid_q <= 1'b1;
            end
        end
    end

    // pin outputs decoded from the state
    always_comb begin
        dram_ras_n = 1'b1;
        dram_cas_n = 1'b1;
        dram_we_n  = 1'b1;
        dram_addr  = row_pad;
        unique case (state_q)
            ST_IDLE, ST_ROW_SET, ST_PRECHARGE: ;
            ST_RAS_WAIT: dram_ras_n = 1'b0;
            ST_COL_SET, ST_PAGE: begin
                dram_ras_n = 1'b0;
                dram_addr  = col_pad;
            end
            ST_COL_ACC: begin
                dram_ras_n = 1'b0;
                dram_cas_n = 1'b0;
                dram_we_n  = !wr_q;
                dram_addr  = col_pad;
            end
            ST_REF_CAS: dram_cas_n = 1'b0;
            ST_REF_RAS: begin
                dram_ras_n = 1'b0;
                dram_cas_n = 1'b0;
            end
            default: ;
        endcase
    end

    assign dram_din  = wdata_q;
    assign rsp_valid = rvalid_q;
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/dram_mux_ctrl_chk.sv
module dram_mux_ctrl_chk #(
    parameter int T_RP  = 4,
    parameter int MUX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             ready,
    input logic             rvalid,
    input logic [MUX_W-1:0] addr
);
    localparam int HW = $clog2(T_RP + 2);
    localparam logic [HW-1:0] HRP = HW'(T_RP);

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) hi_cnt <= HRP;
        else if (!ras_n) hi_cnt <= '0;
        else if (hi_cnt < HRP) hi_cnt <= hi_cnt + 1'b1;
    end

    assert_row_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && cas_n) |-> $stable(addr));

    assert_we_inside_cas_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !cas_n);

    assert_precharge_met_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt >= HRP));

    assert_rsp_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    assert_cbr_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && ras_n) |=> (!ras_n && !cas_n && we_n));

    assert_busy_refresh_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && ras_n) |-> !ready);

    assert_busy_precharge_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && hi_cnt < HRP) |-> !ready);
endmodule

bind dram_mux_ctrl dram_mux_ctrl_chk #(.T_RP(T_RP), .MUX_W(MUX_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ras_n  (dram_ras_n),
    .cas_n  (dram_cas_n),
    .we_n   (dram_we_n),
    .ready  (req_ready),
    .rvalid (rsp_valid),
    .addr   (dram_addr)
);

// File: tb/dram_mux_ctrl_tb.sv
module dram_mux_ctrl_tb;
    localparam int ROW_W = 3, COL_W = 3, DATA_W = 8;
    localparam int T_RCD = 2, T_RAC = 4, T_CAC = 2, T_RP = 3, T_REF_RAS = 4;
    localparam int CLK_MHZ = 125, REFRESH_NS = 400;
    localparam int REF_CYC = CLK_MHZ * REFRESH_NS / 1000;
    localparam int AW = ROW_W + COL_W;
    localparam int NW = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [DATA_W-1:0] rsp_rdata, dram_din;
    logic [DATA_W-1:0] dram_dout = 8'hEE;
    logic [2:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n;

    always #4 clk = ~clk;

    dram_mux_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CLK_MHZ(CLK_MHZ),
        .REFRESH_NS(REFRESH_NS), .T_RCD(T_RCD), .T_RAC(T_RAC), .T_CAC(T_CAC),
        .T_RP(T_RP), .T_REF_RAS(T_REF_RAS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_din(dram_din), .dram_dout(dram_dout)
    );

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    // behavioural memory model, sampled at falling clock edges
    logic [7:0] mem [NW];
    logic pr_ras = 1'b1, pr_cas = 1'b1, pr_rv = 1'b0, in_ref = 1'b0;
    logic [2:0] pr_addr = '0, open_row = '0, col = '0;
    int cyc = 0, ras_t = 0, cas_t = 0, hi_t = 100;
    int ref_count = 0, last_ref = 0, last_gap = 0, max_gap = 0, host_opens = 0;
    int v_pre = 0, v_addr = 0, v_we = 0, v_order = 0, v_busy = 0, v_pulse = 0, v_cbr = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (pr_cas && !dram_cas_n) begin
                if (dram_ras_n) begin
                    ref_count++;
                    if (ref_count > 1) begin
                        last_gap = cyc - last_ref;
                        if (last_gap > max_gap) max_gap = last_gap;
                    end
                    last_ref = cyc;
                end else begin
                    col = dram_addr;
                    cas_t = 0;
                    if (!dram_we_n) mem[{open_row, col}] = dram_din;
                end
            end
            if (pr_ras && !dram_ras_n) begin
                if (hi_t < T_RP) v_pre++;
                if (!dram_cas_n) begin
                    in_ref = 1'b1;
                    if (cyc - last_ref != 1) v_cbr++;
                end else begin
                    open_row = dram_addr;
                    host_opens++;
                    if (dram_addr != pr_addr) v_addr++;
                end
                ras_t = 0;
            end
            if (!pr_ras && dram_ras_n) begin
                if (!in_ref && !pr_cas) v_order++;
                in_ref = 1'b0;
            end
            if (!dram_we_n && (dram_cas_n || in_ref)) v_we++;
            if (dram_ras_n && !dram_cas_n && req_ready) v_busy++;
            if (dram_ras_n && hi_t < T_RP && req_ready) v_busy++;
            if (rsp_valid && pr_rv) v_pulse++;
            if (!dram_ras_n) ras_t++;
            if (!dram_cas_n) cas_t++;
            if (dram_ras_n) hi_t++; else hi_t = 0;
            if (!dram_ras_n && !dram_cas_n && !in_ref && ras_t >= T_RAC && cas_t >= T_CAC)
                dram_dout = mem[{open_row, col}];
            else
                dram_dout = 8'hEE;
            pr_ras = dram_ras_n;
            pr_cas = dram_cas_n;
            pr_addr = dram_addr;
            pr_rv = rsp_valid;
        end
    end

    task automatic host(input bit w, input int a, input logic [7:0] d, output logic [7:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_wdata = d;
        for (int i = 0; i < 200; i++) begin
            #2;
            if (req_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
        rd = 8'h00;
        if (!w) begin
            for (int i = 0; i < 60; i++) begin
                if (rsp_valid) begin
                    rd = rsp_rdata;
                    break;
                end
                @(negedge clk);
            end
        end
    endtask

    task automatic sync_after_refresh();
        int r0;
        r0 = ref_count;
        while (ref_count == r0) @(negedge clk);
        repeat (T_REF_RAS + T_RP + 2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int o0, r0, errs;
        repeat (5) @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes in reset", 0, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes idle", 0, 1);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

        // idle refresh spacing
        while (ref_count < 3) @(negedge clk);
        chk(last_gap == REF_CYC, "R9 idle refresh gap", last_gap, REF_CYC);

        // write every location in row-major order (page hits)
        for (int a = 0; a < NW; a++) host(1'b1, a, pat(a), rd);
        // read back in a scrambled order so rows change often (R8, R6)
        errs = 0;
        for (int k = 0; k < NW; k++) begin
            int a;
            a = (k * 21 + 5) % NW;
            host(1'b0, a, 8'h00, rd);
            if (rd !== pat(a)) begin
                errs++;
                chk(1'b0, "R6 read data", int'(rd), int'(pat(a)));
            end
        end
        chk(errs == 0, "R8 scrambled sweep errors", errs, 0);

        // page mode: four writes to one row open it once
        sync_after_refresh();
        o0 = host_opens; r0 = ref_count;
        for (int c = 0; c < 4; c++) host(1'b1, (5 << COL_W) | c, 8'(8'hA0 + c), rd);
        chk(ref_count == r0, "R7 no refresh in window", ref_count, r0);
        chk(host_opens - o0 == 1, "R7 single row open", host_opens - o0, 1);
        host(1'b0, (5 << COL_W) | 2, 8'h00, rd);
        chk(rd == 8'hA2, "R7 page write data", int'(rd), 'hA2);

        // row change: two reads in different rows open two rows
        sync_after_refresh();
        o0 = host_opens;
        host(1'b0, (2 << COL_W) | 1, 8'h00, rd);
        chk(rd == pat((2 << COL_W) | 1), "R8 first row data", int'(rd), int'(pat((2 << COL_W) | 1)));
        host(1'b0, (6 << COL_W) | 3, 8'h00, rd);
        chk(rd == pat((6 << COL_W) | 3), "R8 second row data", int'(rd), int'(pat((6 << COL_W) | 3)));
        chk(host_opens - o0 == 2, "R8 row openings", host_opens - o0, 2);

        // refresh colliding with continuous same-row traffic
        o0 = host_opens; r0 = ref_count; max_gap = 0; errs = 0;
        for (int n = 0; n < 60; n++) begin
            int a;
            a = (1 << COL_W) | (n % 8);
            host(1'b0, a, 8'h00, rd);
            if (rd !== pat(a)) errs++;
        end
        chk(errs == 0, "R11 reads across refresh", errs, 0);
        chk(ref_count - r0 >= 3, "R11 refreshes served", ref_count - r0, 3);
        chk(host_opens - o0 == ref_count - r0 + 1, "R11 reopen per refresh",
            host_opens - o0, ref_count - r0 + 1);
        chk(max_gap <= REF_CYC + 16, "R9 refresh gap under load", max_gap, REF_CYC + 16);

        chk(v_addr == 0, "R2 row address setup", v_addr, 0);
        chk(v_we == 0, "R3 write strobe window", v_we, 0);
        chk(v_order == 0, "R4 CAS before RAS release", v_order, 0);
        chk(v_pre == 0, "R5 precharge time", v_pre, 0);
        chk(v_pulse == 0, "R6 single-cycle valid", v_pulse, 0);
        chk(v_cbr == 0, "R10 CAS leads RAS by one", v_cbr, 0);
        chk(v_busy == 0, "R12 ready low when busy", v_busy, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule